// File: doc/BRIEF.md
# Counter-Addressed I2C Target

This block is an I2C target that exposes a byte-addressed storage space through one internal address counter. It watches the bus lines on its system clock and detects start, repeated start and stop conditions. It compares the 7-bit device address in each header with its own address and takes the transfer direction from the header's last bit. A write transfer loads the counter from its first data byte. Every later byte of that transfer is stored at the counter position. A read transfer returns bytes from wherever the counter stands. A short write that carries only the pointer byte, followed by a repeated start and a read header, therefore selects the address for the read.

The storage space is split into two populated windows: a low block from 00h to 3Fh and a high block from F0h to FFh. The addresses between them are reserved. The counter advances linearly across the whole 8-bit range and wraps from FFh to 00h, so one long read starting at F0h covers both windows. A `busy_i` input, driven by whatever models slow storage programming, makes the target refuse its own address so that a controller can poll it. The target only ever pulls SDA low and never holds SCL.

Top module: `i2c_ctr_target`

## Requirements
- R1: After reset, `sda_pull_o` is 0, the address counter is 00h, and every populated byte reads 00h.
- R2: A header whose bits 7:1 equal `DEV_ADDR` (bit 0 = 0 for write, 1 for read) is acknowledged with `sda_pull_o` = 1 during the ninth SCL pulse. Any other address is not acknowledged, and the target ignores the rest of that transfer until the next start.
- R3: While `busy_i` is 1 at the end of the address byte, the matching address is not acknowledged. With `busy_i` = 0 the same header is acknowledged.
- R4: In a write transfer, the first data byte loads the counter without storing anything. Each following byte is stored at the counter, and the counter then advances by one. Every write data byte is acknowledged.
- R5: A read transfer without a preceding pointer byte returns data starting at the current counter value.
- R6: A pointer-only write, followed by a repeated start and a read header, makes the read begin at that pointer.
- R7: During a read, each controller ACK (SDA low on the ninth pulse) yields the byte at the next address. A controller NACK ends the read, and `sda_pull_o` is 0 from then on.
- R8: The counter advances linearly with no page wrap and rolls from FFh to 00h. An 80-byte read from F0h returns F0h–FFh followed by 00h–3Fh.
- R9: Addresses 40h–EFh read as FFh. Writes to them change no stored byte, but they still advance the counter.
- R10: A stop condition returns the target to idle with `sda_pull_o` = 0. SCL is input only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired result) |
| busy_i | input | 1 | When 1, the device address is refused |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |

## Verification
The bench uses the default parameters: device address 50h, an 8-bit address space, a low window ending at 3Fh, a high window starting at F0h, and two synchroniser stages. Each bus quarter-bit lasts ten system clocks, so every SCL edge is seen cleanly through the synchronisers. With these values, the boundaries between the windows and the reserved gap (3Fh/40h and EFh/F0h) and the FFh-to-00h wrap are all within a few short transfers. A single 80-byte sweep then compares the whole populated space against a reference model kept in the bench.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ADDR    = 3'd1,
    ST_ADDR_ACK= 3'd2,
    ST_WR      = 3'd3,
    ST_WR_ACK  = 3'd4,
    ST_RD      = 3'd5,
    ST_RD_ACK  = 3'd6
  } tgt_state_e;

  localparam int unsigned BYTE_BITS = 8;

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_sync_q;
  logic [SYNC_STAGES-1:0] sda_sync_q;
  logic                   scl_prev_q;
  logic                   sda_prev_q;
  logic                   scl_s;
  logic                   sda_s;

  // Synchroniser chains; the bus idles high so reset to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sync_q <= {scl_sync_q[SYNC_STAGES-2:0], scl_i};
      sda_sync_q <= {sda_sync_q[SYNC_STAGES-2:0], sda_i};
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign scl_s = scl_sync_q[SYNC_STAGES-1];
  assign sda_s = sda_sync_q[SYNC_STAGES-1];

  always_comb begin
    sda_lvl   = sda_s;
    scl_rise  = scl_s & ~scl_prev_q;
    scl_fall  = ~scl_s & scl_prev_q;
    // SDA edges while SCL stays high mark start and stop
    start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
  end

endmodule

// File: rtl/i2c_space_mem.sv
module i2c_space_mem #(
  parameter int unsigned    AW         = 8,
  parameter int unsigned    DW         = 8,
  parameter logic [AW-1:0]  LOW_LAST   = 8'h3F,
  parameter logic [AW-1:0]  HIGH_FIRST = 8'hF0,
  parameter logic [DW-1:0]  FILL       = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);

  localparam int unsigned LOW_N  = int'(LOW_LAST) + 1;
  localparam int unsigned HIGH_N = (1 << AW) - int'(HIGH_FIRST);
  localparam int unsigned DEPTH  = LOW_N + HIGH_N;
  localparam int unsigned IW     = $clog2(DEPTH);

  logic [DEPTH-1:0][DW-1:0] cells_q;
  logic                     hit_lo;
  logic                     hit_hi;
  logic                     hit;
  logic [IW-1:0]            idx;

  always_comb begin
    hit_lo = (addr <= LOW_LAST);
    hit_hi = (addr >= HIGH_FIRST);
    hit    = hit_lo | hit_hi;
    if (hit_lo) idx = IW'(addr);
    else        idx = IW'(LOW_N) + IW'(addr - HIGH_FIRST);
    rd_data = hit ? cells_q[idx] : FILL;
  end

  // One register per populated byte, each with its own write enable
  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic cell_en;
    assign cell_en = wr_en & hit & (idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cells_q[g] <= '0;
      else if (cell_en) cells_q[g] <= wr_data;
    end
  end

  // R9: a write into the reserved gap leaves every stored byte unchanged
  assert_rsv_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit) |=> $stable(cells_q));

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned   AW       = 8,
  parameter logic [6:0]    DEV_ADDR = 7'h50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          busy_i,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] ctr,
  output logic          wr_en,
  output logic [7:0]    wr_data,
  output logic          sda_pull
);

  localparam int unsigned BCW = $clog2(BYTE_BITS + 1);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(BYTE_BITS);

  tgt_state_e     st_q, st_n;
  logic [BCW-1:0] bc_q, bc_n;
  logic [7:0]     sh_q, sh_n;
  logic           oe_q, oe_n;
  logic [AW-1:0]  ctr_q, ctr_n;
  logic           rw_q, rw_n;
  logic           ptr_q, ptr_n;
  logic           mack_q, mack_n;
  logic           ctr_inc;

  // Next-state process
  always_comb begin
    st_n    = st_q;
    bc_n    = bc_q;
    sh_n    = sh_q;
    oe_n    = oe_q;
    ctr_n   = ctr_q;
    rw_n    = rw_q;
    ptr_n   = ptr_q;
    mack_n  = mack_q;
    wr_en   = 1'b0;
    ctr_inc = 1'b0;

    if (stop_det) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else if (start_det) begin
      st_n = ST_ADDR;
      bc_n = '0;
      oe_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_n = {sh_q[6:0], sda_lvl};
            bc_n = bc_q + 1'b1;
          end else if (scl_fall && bc_q == LAST_BIT) begin
            if (sh_q[7:1] == DEV_ADDR && !busy_i) begin
              oe_n = 1'b1;
              rw_n = sh_q[0];
              st_n = ST_ADDR_ACK;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bc_n = '0;
            if (rw_q) begin
              sh_n = rd_data;
              oe_n = ~rd_data[7];
              st_n = ST_RD;
            end else begin
              oe_n  = 1'b0;
              ptr_n = 1'b1;
              st_n  = ST_WR;
            end
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            sh_n = {sh_q[6:0], sda_lvl};
            bc_n = bc_q + 1'b1;
          end else if (scl_fall && bc_q == LAST_BIT) begin
            oe_n = 1'b1;
            st_n = ST_WR_ACK;
            if (ptr_q) begin
              ctr_n = AW'(sh_q);
              ptr_n = 1'b0;
            end else begin
              wr_en   = 1'b1;
              ctr_inc = 1'b1;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            oe_n = 1'b0;
            bc_n = '0;
            st_n = ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            bc_n = bc_q + 1'b1;
          end else if (scl_fall) begin
            if (bc_q == LAST_BIT) begin
              oe_n    = 1'b0;
              ctr_inc = 1'b1;
              st_n    = ST_RD_ACK;
            end else begin
              sh_n = {sh_q[6:0], 1'b1};
              oe_n = ~sh_q[6];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack_n = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) begin
              sh_n = rd_data;
              oe_n = ~rd_data[7];
              bc_n = '0;
              st_n = ST_RD;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end

    if (ctr_inc) ctr_n = ctr_q + 1'b1;
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bc_q   <= '0;
      sh_q   <= '0;
      oe_q   <= 1'b0;
      ctr_q  <= '0;
      rw_q   <= 1'b0;
      ptr_q  <= 1'b0;
      mack_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      bc_q   <= bc_n;
      sh_q   <= sh_n;
      oe_q   <= oe_n;
      ctr_q  <= ctr_n;
      rw_q   <= rw_n;
      ptr_q  <= ptr_n;
      mack_q <= mack_n;
    end
  end

  assign ctr      = ctr_q;
  assign wr_data  = sh_q;
  assign sda_pull = oe_q;

  // R3: busy at the end of the address byte means no acknowledge
  assert_busy_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ADDR && scl_fall && bc_q == LAST_BIT && busy_i) |=> !oe_q);

  // R4: each completed write byte is acknowledged
  assert_wr_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WR && scl_fall && bc_q == LAST_BIT && !start_det && !stop_det) |=> oe_q);

  // R8: the counter rolls over to zero with no page wrap
  assert_ctr_roll_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_inc && ctr_q == '1) |=> (ctr_q == '0));

  // R10: a stop always leaves SDA released
  assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !oe_q);

endmodule

// File: rtl/i2c_ctr_target.sv
module i2c_ctr_target #(
  parameter logic [6:0]  DEV_ADDR    = 7'h50,
  parameter int unsigned AW          = 8,
  parameter logic [7:0]  LOW_LAST    = 8'h3F,
  parameter logic [7:0]  HIGH_FIRST  = 8'hF0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic busy_i,
  output logic sda_pull_o
);

  logic          sda_lvl;
  logic          scl_rise;
  logic          scl_fall;
  logic          start_det;
  logic          stop_det;
  logic [AW-1:0] ctr;
  logic          wr_en;
  logic [7:0]    wr_data;
  logic [7:0]    rd_data;

  i2c_line_cond #(
    .SYNC_STAGES(SYNC_STAGES)
  ) i_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_target_fsm #(
    .AW      (AW),
    .DEV_ADDR(DEV_ADDR)
  ) i_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .busy_i   (busy_i),
    .rd_data  (rd_data),
    .ctr      (ctr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .sda_pull (sda_pull_o)
  );

  i2c_space_mem #(
    .AW        (AW),
    .DW        (8),
    .LOW_LAST  (AW'(LOW_LAST)),
    .HIGH_FIRST(AW'(HIGH_FIRST)),
    .FILL      (8'hFF)
  ) i_mem (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (ctr),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .rd_data(rd_data)
  );

endmodule

// File: tb/test_i2c_ctr_target.sv
`timescale 1ns/1ps
module test_i2c_ctr_target;

  localparam int QTR  = 10;
  localparam int WDOG = 190000;
  localparam logic [7:0] HW = 8'hA0;
  localparam logic [7:0] HR = 8'hA1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic busy = 1'b0;
  logic sda_pull;
  wire  sda_line = ~(m_low | sda_pull);

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] model [256];

  always #4 clk = ~clk;

  i2c_ctr_target i_i2c_ctr_target (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl),
    .sda_i     (sda_line),
    .busy_i    (busy),
    .sda_pull_o(sda_pull)
  );

  task automatic qwait;
    repeat (QTR) @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp_v);
    end
  endtask

  task automatic bus_start;
    m_low = 1'b1; qwait;
    scl = 1'b0;   qwait;
  endtask

  task automatic bus_rstart;
    m_low = 1'b0; qwait;
    scl = 1'b1;   qwait;
    m_low = 1'b1; qwait;
    scl = 1'b0;   qwait;
  endtask

  task automatic bus_stop;
    m_low = 1'b1; qwait;
    scl = 1'b1;   qwait;
    m_low = 1'b0; qwait;
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; qwait;
      scl = 1'b1;    qwait; qwait;
      scl = 1'b0;    qwait;
    end
    m_low = 1'b0; qwait;
    scl = 1'b1;   qwait;
    ack = ~sda_line; qwait;
    scl = 1'b0;   qwait;
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      qwait;
      scl = 1'b1; qwait;
      b[i] = sda_line; qwait;
      scl = 1'b0; qwait;
    end
    m_low = give_ack; qwait;
    scl = 1'b1; qwait; qwait;
    scl = 1'b0; qwait;
    m_low = 1'b0;
  endtask

  // Pointer-only write, then repeated start into read; reads n bytes
  task automatic read_from(input logic [7:0] a, input int n, input string req);
    bit ack;
    logic [7:0] b;
    bus_start;
    put_byte(HW, ack);
    chk(ack, req, "dummy-write header ack", ack, 1);
    put_byte(a, ack);
    bus_rstart;
    put_byte(HR, ack);
    chk(ack, req, "read header ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      get_byte(k != n - 1, b);
      chk(b == model[8'(a + k)], req, $sformatf("read byte @%0h", 8'(a + k)),
          b, model[8'(a + k)]);
    end
    chk(sda_pull == 1'b0, "R7", "SDA released after NACK", sda_pull, 0);
    bus_stop;
  endtask

  task automatic write_at(input logic [7:0] a, input logic [7:0] d[$]);
    bit ack;
    bus_start;
    put_byte(HW, ack);
    chk(ack, "R2", "write header ack", ack, 1);
    put_byte(a, ack);
    chk(ack, "R4", "pointer byte ack", ack, 1);
    foreach (d[k]) begin
      put_byte(d[k], ack);
      chk(ack, "R4", "data byte ack", ack, 1);
      if (a + k <= 8'h3F || a + k >= 8'hF0) model[8'(a + k)] = d[k];
    end
    bus_stop;
    chk(sda_pull == 1'b0, "R10", "SDA released after stop", sda_pull, 0);
  endtask

  task automatic t_reset;
    bit ack;
    logic [7:0] b;
    chk(sda_pull == 1'b0, "R1", "SDA released in reset", sda_pull, 0);
    // current-address read from reset counter 00h
    bus_start;
    put_byte(HR, ack);
    chk(ack, "R2", "read header ack", ack, 1);
    get_byte(1'b0, b);
    chk(b == 8'h00, "R1", "byte at reset counter", b, 0);
    bus_stop;
  endtask

  task automatic t_write_read;
    bit ack;
    logic [7:0] b;
    write_at(8'h10, '{8'h11, 8'h22, 8'h33, 8'h44});
    read_from(8'h10, 3, "R6");
    // counter now at 13h: a plain read continues there (R5)
    bus_start;
    put_byte(HR, ack);
    get_byte(1'b1, b);
    chk(b == 8'h44, "R5", "current-address read", b, 8'h44);
    get_byte(1'b0, b);
    chk(b == model[8'h14], "R7", "ACK gives next byte", b, model[8'h14]);
    bus_stop;
  endtask

  task automatic t_wrong_addr;
    bit ack;
    bus_start;
    put_byte({7'h23, 1'b0}, ack);
    chk(!ack, "R2", "foreign address nack", ack, 0);
    put_byte(8'h10, ack);
    chk(!ack, "R2", "ignored pointer nack", ack, 0);
    put_byte(8'h99, ack);
    chk(!ack, "R2", "ignored data nack", ack, 0);
    bus_stop;
    read_from(8'h10, 1, "R2");
  endtask

  task automatic t_busy;
    bit ack;
    busy = 1'b1;
    bus_start;
    put_byte(HW, ack);
    chk(!ack, "R3", "busy address nack", ack, 0);
    bus_stop;
    busy = 1'b0;
    bus_start;
    put_byte(HW, ack);
    chk(ack, "R3", "ready address ack", ack, 1);
    bus_stop;
  endtask

  task automatic t_reserved;
    write_at(8'h3F, '{8'h5A, 8'h6B});
    write_at(8'hEF, '{8'hC3, 8'hD4});
    read_from(8'h3E, 4, "R9");
    read_from(8'hEE, 3, "R9");
  endtask

  task automatic t_rollover;
    write_at(8'hFE, '{8'hA1, 8'hA2, 8'hA3});
    read_from(8'hFE, 3, "R8");
    read_from(8'hF0, 80, "R8");
  endtask

  initial begin
    for (int a = 0; a < 256; a++)
      model[a] = (a <= 8'h3F || a >= 8'hF0) ? 8'h00 : 8'hFF;
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    qwait;
    t_reset;
    t_write_read;
    t_wrong_addr;
    t_busy;
    t_reserved;
    t_rollover;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    n_fail++;
    $display("FAIL R1-watchdog run did not finish: actual %0d expected %0d", WDOG, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule